// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-facing register front end of an interrupt routing controller. A bus master reaches every internal register through two byte offsets. It first writes an 8-bit index into a select register and then reads or writes a 32-bit data window that stands in for whichever internal register the index names. The internal registers are a 4-bit identification field, a fixed version word, an arbitration word that always reads as zero, and a routing table with one 64-bit entry per interrupt pin. Software reaches each table entry as a low half and a high half.

The whole table leaves the block as a flat vector for the dispatch logic. After every accepted table write, the block pulses an update strobe and reports the index of the entry that changed, so the dispatch logic can rescan. In the other direction, the dispatch logic can set or clear each entry's in-service flag (bit 14 of the low half). It can also set or clear a per-pin pending vector that this block holds. Read data is registered and arrives one cycle after the read strobe, flagged by a valid output.

Top module: `irq_regwin`

## Requirements
- R1: Only address offsets 0x00 (select) and 0x10 (window) are decoded. A read at any other offset returns zero, and a write there changes no state.
- R2: A write to offset 0x00 stores bits 7:0 of the write data as the select index, whatever the access size. A read of offset 0x00 returns that index zero-extended to 32 bits.
- R3: A window access whose size is not exactly 4 bytes is ignored when it is a write and returns zero when it is a read.
- R4: Select index 0x00 is the identification register. A write keeps write-data bits 27:24 as a 4-bit ID, and a read returns the ID in bits 27:24 with all other bits zero.
- R5: Select index 0x01 always reads 0x00170011: version 0x11 in bits 7:0 and the pin count minus one (23) in bits 23:16. Select index 0x02 always reads zero. Writes to either index change nothing.
- R6: For a select index of 0x10 or above, the table entry is (index − 0x10) >> 1. An odd index reaches bits 63:32 and an even index reaches bits 31:0. If the entry number is 24 or more, or the index is between 0x03 and 0x0F, reads return zero and writes change nothing.
- R7: A window write to one half of an entry replaces exactly that half and leaves the other half unchanged.
- R8: After an accepted table write, the update strobe is high for exactly one cycle, the one after the write. In that same cycle the index output names the written entry and the table output already shows the new value. No other access raises the strobe.
- R9: Reset clears the select index, the ID and the pending vector, and sets every table entry to 0x0000_0000_0001_0000 (only the mask bit, bit 16, set).
- R10: The dispatch set input forces bit 14 of an entry's low half to 1, and its clear input forces that bit to 0. Set wins over clear. Both take priority over a bus write to the same low half in the same cycle, which still writes its other bits.
- R11: The pending vector takes the dispatch pending set and clear inputs one cycle later. Set wins when both name the same pin.
- R12: Read data appears on the read data output in the cycle after the read strobe, with the read-valid output high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset within the block |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| tbl_o | output | NUM_PINS*64 | All routing entries, entry k at bits 64k+63:64k |
| tbl_upd_o | output | 1 | One-cycle pulse after a table write |
| tbl_upd_idx_o | output | IDX_W | Entry written, valid with tbl_upd_o |
| rirr_set_i | input | NUM_PINS | Per-entry set of the in-service flag |
| rirr_clr_i | input | NUM_PINS | Per-entry clear of the in-service flag |
| pend_set_i | input | NUM_PINS | Per-pin pending set |
| pend_clr_i | input | NUM_PINS | Per-pin pending clear |
| pend_o | output | NUM_PINS | Pending vector |

## Verification
A wrong select index or a wrong decode of entry and half shows up as a wrong word on the very next window read. It also shows on the table output one cycle after a write, when the wrong entry or half changes and the update strobe names the wrong index. A bad merge of halves or a lost in-service priority is visible on the table output one cycle after the offending write. Reset errors are visible at the table and pending outputs from the first cycle after reset.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int SEL_W    = 8;
    localparam int ID_W     = 4;
    localparam int ID_LSB   = 24;
    localparam int MASK_BIT = 16;
    localparam int RIRR_BIT = 14;
    localparam int WIN_BYTES = 4;

    localparam logic [ADDR_W-1:0] OFS_SEL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_WIN = 8'h10;

    localparam logic [SEL_W-1:0] IDX_ID       = 8'h00;
    localparam logic [SEL_W-1:0] IDX_VER      = 8'h01;
    localparam logic [SEL_W-1:0] IDX_ARB      = 8'h02;
    localparam logic [SEL_W-1:0] IDX_TBL_BASE = 8'h10;

    localparam logic [7:0] VERSION = 8'h11;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_ID,
        ACC_VER,
        ACC_ARB,
        ACC_TBL
    } acc_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } rte_t;
endpackage

// File: rtl/irq_regwin_decode.sv
module irq_regwin_decode
    import irq_regwin_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W = $clog2(NUM_PINS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic [SEL_W-1:0]  sel,
    output logic              is_sel,
    output logic              is_win,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic              tbl_hi
);
    logic [SEL_W-1:0] rel;
    logic [SEL_W-2:0] full_idx;

    always_comb begin
        is_sel   = (addr == OFS_SEL);
        is_win   = (addr == OFS_WIN) && (int'(size) == WIN_BYTES);
        rel      = sel - IDX_TBL_BASE;
        full_idx = rel[SEL_W-1:1];
        tbl_hi   = sel[0];
        tbl_idx  = full_idx[IDX_W-1:0];
        case (sel)
            IDX_ID:  kind = ACC_ID;
            IDX_VER: kind = ACC_VER;
            IDX_ARB: kind = ACC_ARB;
            default: begin
                if (sel >= IDX_TBL_BASE && int'(full_idx) < NUM_PINS) begin
                    kind = ACC_TBL;
                end else begin
                    kind = ACC_NONE;
                end
            end
        endcase
    end
endmodule

// File: rtl/irq_regwin_entry.sv
module irq_regwin_entry
    import irq_regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rirr_set,
    input  logic              rirr_clr,
    output rte_t              entry_o
);
    rte_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (wr_lo) ent_d.lo = wdata;
        if (wr_hi) ent_d.hi = wdata;
        // dispatch side owns the in-service flag over the bus
        if (rirr_set) begin
            ent_d.lo[RIRR_BIT] = 1'b1;
        end else if (rirr_clr) begin
            ent_d.lo[RIRR_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q.hi <= '0;
            ent_q.lo <= DATA_W'(1) << MASK_BIT;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign entry_o = ent_q;
endmodule

// File: rtl/irq_regwin_rdmux.sv
module irq_regwin_rdmux
    import irq_regwin_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W = $clog2(NUM_PINS)
) (
    input  acc_kind_e                     kind,
    input  logic [IDX_W-1:0]              idx,
    input  logic                          hi,
    input  logic [ID_W-1:0]               id,
    input  logic [NUM_PINS-1:0][63:0]     tbl,
    output logic [DATA_W-1:0]             val
);
    localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

    logic [63:0] ent;

    always_comb begin
        ent = tbl[idx];
        case (kind)
            ACC_ID:  val = DATA_W'(id) << ID_LSB;
            ACC_VER: val = {8'h00, MAX_PIN, 8'h00, VERSION};
            ACC_TBL: val = hi ? ent[63:32] : ent[31:0];
            default: val = '0;
        endcase
    end
endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
    import irq_regwin_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W = $clog2(NUM_PINS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [7:0]               bus_addr,
    input  logic [2:0]               bus_size,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     bus_rvalid,
    output logic [NUM_PINS*64-1:0]   tbl_o,
    output logic                     tbl_upd_o,
    output logic [IDX_W-1:0]         tbl_upd_idx_o,
    input  logic [NUM_PINS-1:0]      rirr_set_i,
    input  logic [NUM_PINS-1:0]      rirr_clr_i,
    input  logic [NUM_PINS-1:0]      pend_set_i,
    input  logic [NUM_PINS-1:0]      pend_clr_i,
    output logic [NUM_PINS-1:0]      pend_o
);
    typedef struct packed {
        logic [SEL_W-1:0]    sel;
        logic [ID_W-1:0]     id;
        logic [NUM_PINS-1:0] pend;
        logic [DATA_W-1:0]   rdata;
        logic                rvalid;
        logic                upd;
        logic [IDX_W-1:0]    upd_idx;
    } st_t;

    st_t st_d, st_q;

    logic                      is_sel, is_win, tbl_hi, tbl_wr;
    acc_kind_e                 kind;
    logic [IDX_W-1:0]          tbl_idx;
    logic [DATA_W-1:0]         win_val;
    logic [NUM_PINS-1:0]       wr_lo, wr_hi;
    logic [NUM_PINS-1:0][63:0] tbl;

    irq_regwin_decode #(.NUM_PINS(NUM_PINS)) u_dec (
        .addr    (bus_addr),
        .size    (bus_size),
        .sel     (st_q.sel),
        .is_sel  (is_sel),
        .is_win  (is_win),
        .kind    (kind),
        .tbl_idx (tbl_idx),
        .tbl_hi  (tbl_hi)
    );

    irq_regwin_rdmux #(.NUM_PINS(NUM_PINS)) u_mux (
        .kind (kind),
        .idx  (tbl_idx),
        .hi   (tbl_hi),
        .id   (st_q.id),
        .tbl  (tbl),
        .val  (win_val)
    );

    assign tbl_wr = bus_wr && is_win && (kind == ACC_TBL);

    always_comb begin
        for (int k = 0; k < NUM_PINS; k++) begin
            wr_lo[k] = tbl_wr && (tbl_idx == IDX_W'(k)) && !tbl_hi;
            wr_hi[k] = tbl_wr && (tbl_idx == IDX_W'(k)) &&  tbl_hi;
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        rte_t ent;
        irq_regwin_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_lo[g]),
            .wr_hi    (wr_hi[g]),
            .wdata    (bus_wdata),
            .rirr_set (rirr_set_i[g]),
            .rirr_clr (rirr_clr_i[g]),
            .entry_o  (ent)
        );
        assign tbl[g] = ent;
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_rd;
        st_d.rdata  = '0;
        st_d.upd    = 1'b0;
        st_d.pend   = (st_q.pend & ~pend_clr_i) | pend_set_i;

        if (bus_wr && is_sel) begin
            st_d.sel = bus_wdata[SEL_W-1:0];
        end
        if (bus_wr && is_win && kind == ACC_ID) begin
            st_d.id = bus_wdata[ID_LSB +: ID_W];
        end
        if (tbl_wr) begin
            st_d.upd     = 1'b1;
            st_d.upd_idx = tbl_idx;
        end
        if (bus_rd) begin
            if (is_sel) begin
                st_d.rdata = DATA_W'(st_q.sel);
            end else if (is_win) begin
                st_d.rdata = win_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata     = st_q.rdata;
    assign bus_rvalid    = st_q.rvalid;
    assign tbl_o         = tbl;
    assign tbl_upd_o     = st_q.upd;
    assign tbl_upd_idx_o = st_q.upd_idx;
    assign pend_o        = st_q.pend;
endmodule

// File: rtl/irq_regwin_chk.sv
module irq_regwin_chk #(
    parameter int NUM_PINS = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [7:0]             bus_addr,
    input logic [2:0]             bus_size,
    input logic [31:0]            bus_rdata,
    input logic                   bus_rvalid,
    input logic [NUM_PINS*64-1:0] tbl_o,
    input logic                   tbl_upd_o,
    input logic [NUM_PINS-1:0]    rirr_set_i,
    input logic [NUM_PINS-1:0]    rirr_clr_i
);
    assert_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    assert_upd_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_upd_o |-> $past(bus_wr && bus_addr == 8'h10 && bus_size == 3'd4));

    assert_size_ign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h10 && bus_size != 3'd4 &&
         rirr_set_i == '0 && rirr_clr_i == '0) |=> ($stable(tbl_o) && !tbl_upd_o));

    assert_other_ofs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != 8'h00 && bus_addr != 8'h10) |=> (bus_rdata == 32'h0));

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        assert_rirr_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
            rirr_set_i[k] |=> tbl_o[k*64 + 14]);
        assert_rirr_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (rirr_clr_i[k] && !rirr_set_i[k]) |=> !tbl_o[k*64 + 14]);
    end
endmodule

bind irq_regwin irq_regwin_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .tbl_o      (tbl_o),
    .tbl_upd_o  (tbl_upd_o),
    .rirr_set_i (rirr_set_i),
    .rirr_clr_i (rirr_clr_i)
);

// File: tb/tb_irq_regwin.sv
module tb_irq_regwin;
    localparam int NP = 24;
    localparam int IW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [2:0]    bus_size = 3'd4;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NP*64-1:0] tbl_o;
    logic          tbl_upd_o;
    logic [IW-1:0] tbl_upd_idx_o;
    logic [NP-1:0] rirr_set_i = '0, rirr_clr_i = '0, pend_set_i = '0, pend_clr_i = '0;
    logic [NP-1:0] pend_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t sb[$];

    always #10 clk = ~clk;

    irq_regwin #(.NUM_PINS(NP)) dut (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ent(int k);
        return tbl_o[k*64 +: 64];
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (sb.size() == 0) begin
                chk("R12 unexpected rvalid", 64'(bus_rvalid), 64'h0);
            end else begin
                rd_item_t it;
                it = sb.pop_front();
                chk(it.tag, 64'(bus_rdata), 64'(it.exp));
            end
        end
    end

    task automatic wr_dp(logic [7:0] a, logic [2:0] sz, logic [31:0] d,
                         logic [NP-1:0] rs, logic [NP-1:0] rc);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        rirr_set_i = rs; rirr_clr_i = rc;
        @(negedge clk);
        bus_wr = 1'b0; rirr_set_i = '0; rirr_clr_i = '0;
    endtask

    task automatic wr(logic [7:0] a, logic [2:0] sz, logic [31:0] d);
        wr_dp(a, sz, d, '0, '0);
    endtask

    task automatic rd(logic [7:0] a, logic [2:0] sz, logic [31:0] exp, string tag);
        rd_item_t it;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_size = sz;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 entry0", ent(0), 64'h0000_0000_0001_0000);
        chk("R9 entry23", ent(NP-1), 64'h0000_0000_0001_0000);
        chk("R9 pend", 64'(pend_o), 64'h0);
        chk("R12 idle rvalid", 64'(bus_rvalid), 64'h0);
        rd(8'h00, 3'd4, 32'h0, "R9 sel reset");
        rd(8'h10, 3'd4, 32'h0, "R9 id reset");

        // R4 ID register
        wr(8'h00, 3'd4, 32'h0);
        wr(8'h10, 3'd4, 32'h5A00_00FF);
        chk("R8 no upd on id", 64'(tbl_upd_o), 64'h0);
        rd(8'h10, 3'd4, 32'h0A00_0000, "R4 id read");

        // R5 version and arbitration
        wr(8'h00, 3'd1, 32'h01);
        rd(8'h10, 3'd4, 32'h0017_0011, "R5 version");
        wr(8'h10, 3'd4, 32'hFFFF_FFFF);
        rd(8'h10, 3'd4, 32'h0017_0011, "R5 version after write");
        wr(8'h00, 3'd4, 32'h02);
        wr(8'h10, 3'd4, 32'hFFFF_FFFF);
        rd(8'h10, 3'd4, 32'h0, "R5 arb");

        // R6 R7 R8 table halves
        wr(8'h00, 3'd4, 32'h12);
        wr(8'h10, 3'd4, 32'h0000_00A5);
        chk("R8 upd pulse", 64'(tbl_upd_o), 64'h1);
        chk("R8 upd idx", 64'(tbl_upd_idx_o), 64'd1);
        chk("R8 table visible", ent(1), 64'h0000_0000_0000_00A5);
        @(negedge clk);
        chk("R8 upd single", 64'(tbl_upd_o), 64'h0);
        rd(8'h10, 3'd4, 32'h0000_00A5, "R6 entry1 low");
        wr(8'h00, 3'd4, 32'h13);
        wr(8'h10, 3'd4, 32'hFF00_0000);
        chk("R7 both halves", ent(1), 64'hFF00_0000_0000_00A5);
        rd(8'h10, 3'd4, 32'hFF00_0000, "R6 entry1 high");
        wr(8'h00, 3'd4, 32'h2F);
        wr(8'h10, 3'd4, 32'h1234_5678);
        chk("R8 upd idx 15", 64'(tbl_upd_idx_o), 64'd15);
        chk("R7 entry15 low kept", ent(15), 64'h1234_5678_0001_0000);
        chk("R6 entry14 untouched", ent(14), 64'h0000_0000_0001_0000);

        // R6 out of range
        wr(8'h00, 3'd4, 32'h40);
        wr(8'h10, 3'd4, 32'hFFFF_FFFF);
        chk("R6 oor no upd", 64'(tbl_upd_o), 64'h0);
        chk("R6 oor entry23", ent(NP-1), 64'h0000_0000_0001_0000);
        rd(8'h10, 3'd4, 32'h0, "R6 oor read");
        wr(8'h00, 3'd4, 32'h05);
        rd(8'h10, 3'd4, 32'h0, "R6 gap read");

        // R3 size
        wr(8'h00, 3'd4, 32'h12);
        wr(8'h10, 3'd2, 32'h0000_DEAD);
        chk("R3 no upd", 64'(tbl_upd_o), 64'h0);
        chk("R3 entry kept", ent(1), 64'hFF00_0000_0000_00A5);
        rd(8'h10, 3'd1, 32'h0, "R3 short read");
        rd(8'h10, 3'd4, 32'h0000_00A5, "R3 full read");

        // R1 other offsets
        rd(8'h20, 3'd4, 32'h0, "R1 other offset read");
        wr(8'h04, 3'd4, 32'hFF);
        rd(8'h00, 3'd4, 32'h12, "R1 sel unchanged");

        // R10 in-service flag
        @(negedge clk);
        rirr_set_i[1] = 1'b1;
        @(negedge clk);
        rirr_set_i = '0;
        chk("R10 set", ent(1), 64'hFF00_0000_0000_40A5);
        wr_dp(8'h10, 3'd4, 32'h0000_00B6, NP'(2), '0);
        chk("R10 set beats write", ent(1), 64'hFF00_0000_0000_40B6);
        wr_dp(8'h10, 3'd4, 32'h0000_4077, '0, NP'(2));
        chk("R10 clr beats write", ent(1), 64'hFF00_0000_0000_0077);
        wr(8'h10, 3'd4, 32'h0000_4011);
        chk("R10 plain write", ent(1), 64'hFF00_0000_0000_4011);

        // R11 pending
        @(negedge clk);
        pend_set_i = NP'(5);
        @(negedge clk);
        pend_set_i = NP'(4); pend_clr_i = NP'(5);
        chk("R11 set", 64'(pend_o), 64'h5);
        @(negedge clk);
        pend_set_i = '0; pend_clr_i = NP'(4);
        chk("R11 set wins", 64'(pend_o), 64'h4);
        @(negedge clk);
        pend_clr_i = '0;
        chk("R11 clear", 64'(pend_o), 64'h0);

        // R2 select
        wr(8'h00, 3'd2, 32'hABCD_12F3);
        rd(8'h00, 3'd4, 32'h0000_00F3, "R2 sel zero-extend");

        repeat (3) @(negedge clk);
        chk("R12 scoreboard drained", 64'(sb.size()), 64'h0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule